// File: doc/BRIEF.md
# Cubic Nonlinearity Correction Evaluator

This block sits beside a 14-bit main converter and computes, for every code sent to that converter, a small correction. The correction drives a 6-bit auxiliary converter whose analog output is summed with the main output. The correction is a third-order polynomial in the code. Its four signed coefficients come from an off-line characterisation pass, which loads them through a simple register write port.

The code is read as an unsigned fraction u = code / 2^CODE_W. Each coefficient is a signed COEF_W-bit fixed-point number with FRAC_W fraction bits. Its unit is one step of the auxiliary converter. The block evaluates the polynomial in nested (Horner) form in a four-stage pipeline and accepts one code per clock. It rounds the result to whole auxiliary steps and clamps it to the signed 6-bit range. Coefficient writes land in a shadow set, and a commit strobe copies the whole set into the working registers at once. A sample is therefore always evaluated with a single coherent set.

Top module: `inl_cubic_corr`

## Requirements
- R1: In a cycle with code_vld high, let a3 = b3. For k = 2, 1, 0, a_k = floor(a_(k+1)·code / 2^14) + b_k. The floor is taken over the full signed product.
- R2: The correction is floor((a0 + 128) / 256), so a value exactly halfway between two steps goes to the step above. For example, b0 = 128 with the other coefficients zero gives +1, and b0 = -128 gives 0.
- R3: A rounded value above +31 is output as +31, and a value below -32 is output as -32. corr is two's complement.
- R4: corr_vld equals code_vld from four clock edges earlier. Back-to-back samples each produce their own result, one per clock.
- R5: While corr_vld is low, corr is zero.
- R6: The bypass input is captured together with the code. A sample taken with bypass high comes out as zero, with corr_vld still high.
- R7: Writing with cf_wr_en loads the shadow coefficient selected by cf_wr_sel (0 = b0, 1 = b1, 2 = b2, 3 = b3). A write has no effect on any result until a commit.
- R8: cf_commit copies all four shadow values into the working set at that clock edge. A sample presented in the commit cycle uses the old set, and later samples use the new one. A write in the commit cycle itself is not part of that commit.
- R9: Reset (rst high, synchronous) clears both coefficient sets and the pipeline, so corr_vld = 0 and corr = 0. Samples after reset give zero until a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_vld | input | 1 | Code input is valid this cycle |
| code | input | 14 | Main converter code, unsigned |
| bypass | input | 1 | Force the correction of this sample to zero |
| cf_wr_en | input | 1 | Shadow coefficient write strobe |
| cf_wr_sel | input | 2 | Coefficient index (0 = b0 … 3 = b3) |
| cf_wr_data | input | 16 | Signed coefficient, 8 fraction bits |
| cf_commit | input | 1 | Copy shadow set into the working set |
| corr_vld | output | 1 | Correction output is valid |
| corr | output | 6 | Signed correction for the auxiliary converter |

## Verification
The assertions take for granted that reset is held for at least one clock before the first sample. They also assume that code_vld, cf_wr_en and cf_commit are low while reset is high, since the latency and commit properties count only cycles after reset has been released. The stimulus drives every control input low throughout reset and changes inputs only on the falling clock edge. Beyond that, any mix of writes, commits, bubbles and bypass is legal input, and the bench drives such mixes, including a write and a commit in the same cycle and commits while samples are in flight.

// File: rtl/inl_corr_pkg.sv
package inl_corr_pkg;
  localparam int NUM_COEF   = 4;
  localparam int COEF_SEL_W = $clog2(NUM_COEF);
  localparam int PIPE_LAT   = 4;

  typedef enum logic [COEF_SEL_W-1:0] {
    CIX_B0 = 2'd0,
    CIX_B1 = 2'd1,
    CIX_B2 = 2'd2,
    CIX_B3 = 2'd3
  } coef_idx_e;
endpackage

// File: rtl/inl_coef_bank.sv
module inl_coef_bank
  import inl_corr_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [COEF_SEL_W-1:0]        wr_sel,
  input  logic [COEF_W-1:0]            wr_data,
  input  logic                         commit,
  output logic [NUM_COEF*COEF_W-1:0]   act_flat
);
  logic [COEF_W-1:0] shadow [NUM_COEF];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_COEF; i++) shadow[i] <= '0;
      act_flat <= '0;
    end else begin
      if (wr_en) shadow[wr_sel] <= wr_data;
      if (commit)
        for (int i = 0; i < NUM_COEF; i++) act_flat[i*COEF_W +: COEF_W] <= shadow[i];
    end
  end

  for (genvar g = 0; g < NUM_COEF; g++) begin : g_chk
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (rst)
      commit |=> act_flat[g*COEF_W +: COEF_W] == $past(shadow[g])); // R8
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_flat)); // R7
endmodule

// File: rtl/inl_horner_step.sv
module inl_horner_step #(
  parameter int CODE_W = 14,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld_in,
  input  logic                     byp_in,
  input  logic [CODE_W-1:0]        x_in,
  input  logic signed [ACC_W-1:0]  acc_in,
  input  logic signed [COEF_W-1:0] add_in,
  output logic                     vld_out,
  output logic                     byp_out,
  output logic [CODE_W-1:0]        x_out,
  output logic signed [ACC_W-1:0]  acc_out
);
  localparam int PROD_W = ACC_W + CODE_W + 1;

  logic signed [PROD_W-1:0] a_ext, x_ext, prod;
  logic signed [ACC_W-1:0]  add_ext, nxt;

  always_comb begin
    a_ext   = PROD_W'(acc_in);
    x_ext   = PROD_W'({1'b0, x_in});
    prod    = a_ext * x_ext;
    add_ext = ACC_W'(add_in);
    nxt     = ACC_W'(prod >>> CODE_W) + add_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out <= 1'b0;
      byp_out <= 1'b0;
    end else begin
      vld_out <= vld_in;
      byp_out <= byp_in;
    end
    x_out   <= x_in;
    acc_out <= nxt;
  end

  AST_STEP_VLD: assert property (@(posedge clk) disable iff (rst)
    vld_in |=> vld_out); // R4
  AST_STEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !vld_in |=> !vld_out); // R4
endmodule

// File: rtl/inl_round_sat.sv
module inl_round_sat #(
  parameter int ACC_W  = 18,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_in,
  input  logic                    byp_in,
  input  logic signed [ACC_W-1:0] acc_in,
  output logic                    corr_vld,
  output logic [OUT_W-1:0]        corr
);
  localparam int RND_W = ACC_W + 1 - FRAC_W;
  localparam logic signed [ACC_W:0]   HALF = (ACC_W+1)'(1 << (FRAC_W-1));
  localparam logic signed [RND_W-1:0] MAXV = RND_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [RND_W-1:0] MINV = RND_W'(-(1 << (OUT_W-1)));

  logic signed [ACC_W:0]   rsum;
  logic signed [RND_W-1:0] rnd;
  logic [OUT_W-1:0]        sat;

  always_comb begin
    rsum = (ACC_W+1)'(acc_in) + HALF;
    rnd  = RND_W'(rsum >>> FRAC_W);
    if (rnd > MAXV)      sat = OUT_W'(MAXV);
    else if (rnd < MINV) sat = OUT_W'(MINV);
    else                 sat = OUT_W'(rnd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_vld <= 1'b0;
      corr     <= '0;
    end else begin
      corr_vld <= vld_in;
      corr     <= (vld_in && !byp_in) ? sat : '0;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !corr_vld |-> corr == '0); // R5
  AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (vld_in && byp_in) |=> (corr_vld && corr == '0)); // R6
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (vld_in && !byp_in && rnd > MAXV) |=> corr == OUT_W'(MAXV)); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (vld_in && !byp_in && rnd < MINV) |=> corr == OUT_W'(MINV)); // R3
endmodule

// File: rtl/inl_cubic_corr.sv
module inl_cubic_corr
  import inl_corr_pkg::*;
#(
  parameter int CODE_W = 14,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  code_vld,
  input  logic [CODE_W-1:0]     code,
  input  logic                  bypass,
  input  logic                  cf_wr_en,
  input  logic [COEF_SEL_W-1:0] cf_wr_sel,
  input  logic [COEF_W-1:0]     cf_wr_data,
  input  logic                  cf_commit,
  output logic                  corr_vld,
  output logic [OUT_W-1:0]      corr
);
  localparam int ACC_W = COEF_W + 2;

  logic [NUM_COEF*COEF_W-1:0] act_flat;
  logic signed [COEF_W-1:0]   b0, b1, b2, b3;
  logic signed [COEF_W-1:0]   s1_b1, s1_b0, s2_b0;

  logic                     v1, v2, v3, p1, p2, p3;
  logic [CODE_W-1:0]        x1, x2, x3;
  logic signed [ACC_W-1:0]  a2, a1, a0, b3_ext;

  inl_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cf_wr_en), .wr_sel(cf_wr_sel),
    .wr_data(cf_wr_data), .commit(cf_commit), .act_flat(act_flat)
  );

  always_comb begin
    b0     = $signed(act_flat[int'(CIX_B0)*COEF_W +: COEF_W]);
    b1     = $signed(act_flat[int'(CIX_B1)*COEF_W +: COEF_W]);
    b2     = $signed(act_flat[int'(CIX_B2)*COEF_W +: COEF_W]);
    b3     = $signed(act_flat[int'(CIX_B3)*COEF_W +: COEF_W]);
    b3_ext = ACC_W'(b3);
  end

  // Lower-order coefficients travel with their sample so a commit never splits one.
  always_ff @(posedge clk) begin
    s1_b1 <= b1;
    s1_b0 <= b0;
    s2_b0 <= s1_b0;
  end

  inl_horner_step #(.CODE_W(CODE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_st3 (
    .clk(clk), .rst(rst), .vld_in(code_vld), .byp_in(bypass), .x_in(code),
    .acc_in(b3_ext), .add_in(b2),
    .vld_out(v1), .byp_out(p1), .x_out(x1), .acc_out(a2)
  );

  inl_horner_step #(.CODE_W(CODE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_st2 (
    .clk(clk), .rst(rst), .vld_in(v1), .byp_in(p1), .x_in(x1),
    .acc_in(a2), .add_in(s1_b1),
    .vld_out(v2), .byp_out(p2), .x_out(x2), .acc_out(a1)
  );

  inl_horner_step #(.CODE_W(CODE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_st1 (
    .clk(clk), .rst(rst), .vld_in(v2), .byp_in(p2), .x_in(x2),
    .acc_in(a1), .add_in(s2_b0),
    .vld_out(v3), .byp_out(p3), .x_out(x3), .acc_out(a0)
  );

  inl_round_sat #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .vld_in(v3), .byp_in(p3), .acc_in(a0),
    .corr_vld(corr_vld), .corr(corr)
  );

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                     since_rst <= '0;
    else if (since_rst < 3'(PIPE_LAT)) since_rst <= since_rst + 3'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'(PIPE_LAT)) |-> corr_vld == $past(code_vld, 4)); // R4
  AST_CODE_UNUSED_LAST: assert property (@(posedge clk) disable iff (rst)
    v3 |-> x3 == $past(code, 3)); // R1
endmodule

// File: tb/sim_inl_cubic_corr.sv
module sim_inl_cubic_corr;
  localparam int CW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic code_vld = 1'b0, bypass = 1'b0;
  logic [13:0] code = '0;
  logic cf_wr_en = 1'b0, cf_commit = 1'b0;
  logic [1:0] cf_wr_sel = '0;
  logic [15:0] cf_wr_data = '0;
  logic corr_vld;
  logic [5:0] corr;

  always #10 clk = ~clk;

  inl_cubic_corr u0 (
    .clk(clk), .rst(rst), .code_vld(code_vld), .code(code), .bypass(bypass),
    .cf_wr_en(cf_wr_en), .cf_wr_sel(cf_wr_sel), .cf_wr_data(cf_wr_data),
    .cf_commit(cf_commit), .corr_vld(corr_vld), .corr(corr)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // Reference model state
  logic [15:0] m_act [4];
  logic [15:0] m_shd [4];
  bit fresh = 1;
  bit  pv [4];
  int  pe [4];
  int  pt [4];

  function automatic longint sx(logic [15:0] w);
    return longint'($signed(w));
  endfunction

  function automatic longint horner(longint x);
    longint a;
    a = sx(m_act[3]);
    a = ((a * x) >>> CW) + sx(m_act[2]);
    a = ((a * x) >>> CW) + sx(m_act[1]);
    a = ((a * x) >>> CW) + sx(m_act[0]);
    return a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_act[i] = '0; m_shd[i] = '0; pv[i] = 0; pe[i] = 0; pt[i] = 5; end
      fresh = 1;
    end else begin
      longint a, r;
      int t;
      bit pend;
      for (int i = 3; i > 0; i--) begin pv[i] = pv[i-1]; pe[i] = pe[i-1]; pt[i] = pt[i-1]; end
      a = horner(longint'(code));
      r = (a + 128) >>> 8;
      pend = 0;
      for (int i = 0; i < 4; i++) if (m_shd[i] != m_act[i]) pend = 1;
      if (bypass)                 t = 6;
      else if (r > 31 || r < -32) t = 3;
      else if ((a & 255) == 128)  t = 2;
      else if (cf_commit)         t = 8;
      else if (fresh)             t = 9;
      else if (pend)              t = 7;
      else                        t = 1;
      if (r > 31) r = 31;
      if (r < -32) r = -32;
      pv[0] = code_vld;
      pe[0] = (code_vld && !bypass) ? int'(r) : 0;
      pt[0] = code_vld ? t : 5;
      if (cf_commit) begin
        for (int i = 0; i < 4; i++) m_act[i] = m_shd[i];
        fresh = 0;
      end
      if (cf_wr_en) m_shd[cf_wr_sel] = cf_wr_data;
    end
  end

  function automatic string tname(int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9";
      default: return "R4";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      int got;
      got = int'($signed(corr));
      n_chk++;
      if (corr_vld !== pv[3]) begin
        n_fail++;
        $display("FAIL R4 corr_vld actual=%0b expected=%0b", corr_vld, pv[3]);
      end
      n_chk++;
      if (got != pe[3]) begin
        n_fail++;
        $display("FAIL %s corr actual=%0d expected=%0d", tname(pt[3]), got, pe[3]);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic step(bit v, int c, bit b, bit we, int sel, int d, bit cm);
    @(negedge clk);
    code_vld = v; code = 14'(c); bypass = b;
    cf_wr_en = we; cf_wr_sel = 2'(sel); cf_wr_data = 16'(d); cf_commit = cm;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(int c0, int c1, int c2, int c3);
    step(0, 0, 0, 1, 0, c0, 0);
    step(0, 0, 0, 1, 1, c1, 0);
    step(0, 0, 0, 1, 2, c2, 0);
    step(0, 0, 0, 1, 3, c3, 0);
    step(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state at the ports
    n_chk++;
    if (corr_vld !== 1'b0 || corr !== 6'd0) begin
      n_fail++;
      $display("FAIL R9 after reset actual=%0b/%0d expected=0/0", corr_vld, corr);
    end
    // R9: samples with cleared coefficients
    for (int i = 0; i < 4; i++) step(1, i * 5000, 0, 0, 0, 0, 0);
    // R7: shadow writes with no commit leave results at zero
    step(0, 0, 0, 1, 0, 16'h0A00, 0);
    step(0, 0, 0, 1, 3, 16'h1000, 0);
    for (int i = 0; i < 6; i++) step(1, 16383 - i * 700, 0, 0, 0, 0, 0);
    idle(5);
    // R1: typical cubic, ramp across the range
    load(-768, 2048, -1024, 512);
    for (int c = 0; c < 16384; c += 1024) step(1, c, 0, 0, 0, 0, 0);
    step(1, 16383, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    // R2: half-step rounding
    load(128, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, i * 3000, 0, 0, 0, 0, 0);
    load(-128, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, i * 3000, 0, 0, 0, 0, 0);
    load(-384, 0, 0, 0);
    step(1, 77, 0, 0, 0, 0, 0);
    // R3: saturation at both ends
    load(32767, 32767, 32767, 32767);
    for (int i = 0; i < 4; i++) step(1, i * 5000, 0, 0, 0, 0, 0);
    load(-32768, -32768, -32768, -32768);
    for (int i = 0; i < 4; i++) step(1, i * 5000 + 1, 0, 0, 0, 0, 0);
    load(7935, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    // R6: bypass with large coefficients
    for (int i = 0; i < 6; i++) step(1, i * 2000, i % 2, 0, 0, 0, 0);
    // R8: commit while streaming, write in the same cycle as commit
    step(1, 100, 0, 1, 0, 2000, 0);
    step(1, 9000, 0, 1, 1, -3000, 0);
    step(1, 12000, 0, 1, 2, 700, 1);
    step(1, 15000, 0, 0, 0, 0, 0);
    step(1, 16000, 0, 0, 0, 0, 1);
    step(1, 4000, 0, 0, 0, 0, 0);
    // R4, R1: random coefficient sets, random bubbles and bypass
    for (int s = 0; s < 25; s++) begin
      load(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)));
      for (int k = 0; k < 30; k++)
        step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 16383)),
             ($urandom_range(0, 7) == 0), 0, 0, 0, 0);
    end
    // R1: moderate random sets that stay in range
    for (int s = 0; s < 10; s++) begin
      load(int'($urandom_range(0, 4000)) - 2000, int'($urandom_range(0, 4000)) - 2000,
           int'($urandom_range(0, 4000)) - 2000, int'($urandom_range(0, 4000)) - 2000);
      for (int k = 0; k < 20; k++) step(1, int'($urandom_range(0, 16383)), 0, 0, 0, 0, 0);
    end
    idle(8);
    finish_run();
  end
endmodule